// File: doc/BRIEF.md
# Mode-Banked Three-Port Register File

This block is the register storage of a small 32-bit RISC core. The instruction stream sees sixteen registers, named by a 4-bit number. Behind them are 25 physical words: fifteen shared general words, nine private copies used by the exception modes, and a trimmed program counter. A 2-bit mode input picks which copy a register number reaches. An interrupt handler therefore works on its own stack pointer and link register, and the fast interrupt also gets its own r10 to r12, without saving the interrupted code's values.

Each cycle, two source operands are read through two independent combinational ports, and one result is written at the clock edge. Register 15 is the program counter. Only its address bits [25:2] are kept: the upper six bits and the lower two bits read back as zero. A second write path into the PC lets the fetch logic advance it in the same cycle that the core writes a different register. A synchronous reset clears the PC and leaves all other words untouched.

Top module: `bankedRegFile`

## Requirements
- R1: Each read port returns, in the same cycle, the word selected by its 4-bit register number and the present mode.
- R2: With `wrEn` high, `wrData` is stored at the rising edge into the word selected by `wrAddr` and the present mode, and it can be read from the next cycle.
- R3: Mode 2'b00 (user) maps r0–r14 to the shared words. Mode 2'b01 (fast interrupt) gives r10–r14 private words. Mode 2'b10 (interrupt) and mode 2'b11 (supervisor) each give r13–r14 private words. Every other register number in every mode reaches the shared word.
- R4: The mode value present in the cycle of an access selects the bank, for reads and for writes alike.
- R5: Reading r15 returns zero in bits [31:26] and [1:0]. Writes to those bits are discarded, and bits [25:2] keep the written value.
- R6: A read of the word being written in the same cycle returns the old value.
- R7: A synchronous `rst` high at a rising edge sets the PC to zero.
- R8: With `pcIncEn` high, bits [25:2] of `pcIncData` are loaded into the PC at the edge. If `wrEn` is high with `wrAddr` = 15 in the same cycle, `wrData` is stored instead.
- R9: A PC update through `pcIncEn` and a write to another register in the same cycle both take effect.
- R10: Both read ports may address any register, including the same one, and they do not affect each other.
- R11: r15 is a single word that all four modes share.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the PC |
| mode | input | 2 | Bank select: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor |
| rdAddrA | input | 4 | Register number for read port A |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Register number for read port B |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable for the destination port |
| wrAddr | input | 4 | Destination register number |
| wrData | input | 32 | Destination write data |
| pcIncEn | input | 1 | Enable for the PC update path |
| pcIncData | input | 32 | New PC value from the fetch logic |

## Verification
On every cycle, the checker confirms several properties. The write selection never addresses more than one word. The PC's unused bits always read as zero. Port A data does not change when no write occurred and neither its register number nor the mode moved. A non-PC write can be read back in the following cycle under the same mode. It also checks that the PC reads zero right after reset. The bench's scenarios are what show the bank mapping in every mode, that private copies survive writes made in other modes, old-value reads during a write, and the priority between the two PC paths. The bench compares both ports against its own model on every clock.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_ARCH = 16;
  localparam int NUM_GPR  = 24;           // shared r0..r14 plus nine banked words
  localparam int NUM_PHYS = NUM_GPR + 1;  // plus the trimmed PC
  localparam int PC_IDX   = NUM_GPR;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int REG_W    = $clog2(NUM_ARCH);

  typedef enum logic [1:0] {
    MODE_USR  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_SVC  = 2'b11
  } rfMode_e;

  typedef struct packed {
    logic [NUM_PHYS-1:0] rdSelA;
    logic [NUM_PHYS-1:0] rdSelB;
    logic [NUM_PHYS-1:0] wrSel;
    logic                pcBump;
  } rfStrobe_t;

  // Physical layout: 0..14 shared, 15..19 fast r10..r14,
  // 20..21 interrupt r13..r14, 22..23 supervisor r13..r14, 24 PC.
  function automatic logic [PHYS_W-1:0] physIndex(input logic [1:0] mode,
                                                  input logic [REG_W-1:0] regNum);
    logic [PHYS_W-1:0] idx;
    idx = PHYS_W'(regNum);
    if (regNum == REG_W'(NUM_ARCH - 1)) begin
      idx = PHYS_W'(PC_IDX);
    end else begin
      case (rfMode_e'(mode))
        MODE_FAST: if (regNum >= REG_W'(10)) idx = PHYS_W'(regNum) + PHYS_W'(5);
        MODE_IRQ:  if (regNum >= REG_W'(13)) idx = PHYS_W'(regNum) + PHYS_W'(7);
        MODE_SVC:  if (regNum >= REG_W'(13)) idx = PHYS_W'(regNum) + PHYS_W'(9);
        default:   idx = PHYS_W'(regNum);
      endcase
    end
    return idx;
  endfunction
endpackage

// File: rtl/rf_port_decode.sv
module rf_port_decode
  import rf_pkg::*;
(
  input  logic [1:0]          mode,
  input  logic [REG_W-1:0]    regId,
  input  logic                enable,
  output logic [NUM_PHYS-1:0] sel
);
  always_comb begin
    sel = '0;
    if (enable) sel[physIndex(mode, regId)] = 1'b1;
  end
endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] rdAddrA,
  input  logic [REG_W-1:0] rdAddrB,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrAddr,
  input  logic             pcIncEn,
  output rfStrobe_t        strobe
);
  localparam int NUM_PORTS = 3;

  logic [REG_W-1:0]    portId  [NUM_PORTS];
  logic                portEn  [NUM_PORTS];
  logic [NUM_PHYS-1:0] portSel [NUM_PORTS];

  assign portId[0] = rdAddrA;
  assign portId[1] = rdAddrB;
  assign portId[2] = wrAddr;
  assign portEn[0] = 1'b1;
  assign portEn[1] = 1'b1;
  assign portEn[2] = wrEn;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_decode
    rf_port_decode u_dec (
      .mode   (mode),
      .regId  (portId[p]),
      .enable (portEn[p]),
      .sel    (portSel[p])
    );
  end

  assign strobe.rdSelA = portSel[0];
  assign strobe.rdSelB = portSel[1];
  assign strobe.wrSel  = portSel[2];
  assign strobe.pcBump = pcIncEn;
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  rfStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIncData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int PC_W = PC_HI - PC_LO + 1;

  logic [DATA_W-1:0] gpr [NUM_GPR];
  logic [PC_W-1:0]   pcWord;
  logic [DATA_W-1:0] pcFull;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_GPR; i++) begin
      if (strobe.wrSel[i]) gpr[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         pcWord <= '0;
    else if (strobe.wrSel[PC_IDX])   pcWord <= wrData[PC_HI:PC_LO];
    else if (strobe.pcBump)          pcWord <= pcIncData[PC_HI:PC_LO];
  end

  always_comb begin
    pcFull = '0;
    pcFull[PC_HI:PC_LO] = pcWord;
  end

  logic [NUM_PHYS-1:0] rdSel  [2];
  logic [DATA_W-1:0]   rdWord [2];
  assign rdSel[0] = strobe.rdSelA;
  assign rdSel[1] = strobe.rdSelB;

  for (genvar p = 0; p < 2; p++) begin : g_read
    always_comb begin
      rdWord[p] = '0;
      for (int i = 0; i < NUM_GPR; i++) begin
        if (rdSel[p][i]) rdWord[p] = rdWord[p] | gpr[i];
      end
      if (rdSel[p][PC_IDX]) rdWord[p] = rdWord[p] | pcFull;
    end
  end

  assign rdDataA = rdWord[0];
  assign rdDataB = rdWord[1];
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcIncEn,
  input  logic [DATA_W-1:0] pcIncData
);
  rfStrobe_t           strobe;
  logic [NUM_PHYS-1:0] wrSelBus;

  rf_ctrl u_ctrl (
    .mode    (mode),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .pcIncEn (pcIncEn),
    .strobe  (strobe)
  );

  rf_datapath #(.DATA_W(DATA_W), .PC_HI(PC_HI), .PC_LO(PC_LO)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (wrData),
    .pcIncData (pcIncData),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB)
  );

  assign wrSelBus = strobe.wrSel;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode,
  input logic [3:0]          rdAddrA,
  input logic [DATA_W-1:0]   rdDataA,
  input logic                wrEn,
  input logic [3:0]          wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input logic                pcIncEn,
  input logic [NUM_PHYS-1:0] wrSelBus
);
  // Destination decode touches at most one word (R2)
  p_single_dest_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrSelBus));

  // Unused PC bits read as zero (R5)
  p_pc_trim_r5: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == 4'hF) |-> (rdDataA[DATA_W-1:PC_HI+1] == '0 && rdDataA[PC_LO-1:0] == '0));

  // PC is zero in the cycle after reset (R7)
  p_pc_reset_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rdAddrA == 4'hF) |-> (rdDataA == '0));

  // Without any write, an unchanged port address and mode keep the data (R1)
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !pcIncEn) |=> (($stable(rdAddrA) && $stable(mode)) |-> $stable(rdDataA)));

  // A non-PC write is read back next cycle under the same mode (R2, R4)
  p_write_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != 4'hF) |=>
      ((rdAddrA == $past(wrAddr) && mode == $past(mode)) |-> (rdDataA == $past(wrData))));
endmodule

bind bankedRegFile rf_checker #(.DATA_W(DATA_W), .PC_HI(PC_HI), .PC_LO(PC_LO)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .rdAddrA  (rdAddrA),
  .rdDataA  (rdDataA),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .pcIncEn  (pcIncEn),
  .wrSelBus (wrSelBus)
);

// File: tb/bankedRegFile_test.sv
`timescale 1ns/1ps
module bankedRegFile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  rdAddrA = 4'hF, rdAddrB = 4'hF, wrAddr = 4'h0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, pcIncData = '0;
  logic        wrEn = 1'b0, pcIncEn = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bankedRegFile uut (
    .clk(clk), .rst(rst), .mode(mode),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pcIncEn(pcIncEn), .pcIncData(pcIncData)
  );

  // Behavioural model: one 16-entry view per mode, plus a note of which
  // view really owns each (mode, register) pair.
  logic [31:0] view [4][16];
  logic [31:0] pcModel = '0;
  localparam logic [31:0] PC_MASK = 32'h03FF_FFFC;

  function automatic int owner(input int m, input int r);
    if (m == 1 && r >= 10 && r <= 14) return 1;
    if ((m == 2 || m == 3) && (r == 13 || r == 14)) return m;
    return 0;
  endfunction

  function automatic logic [31:0] mdlRead(input int m, input int r);
    if (r == 15) return pcModel;
    return view[owner(m, r)][r];
  endfunction

  task automatic check(input string tag, input string port, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s port %s mode=%0d: got %h expected %h", tag, port, mode, got, exp);
    end
  endtask

  // Drive one cycle, check both ports before the edge, then update the model.
  task automatic step(input string tag, input int m, input int a, input int b,
                      input bit we, input int wa, input logic [31:0] wd,
                      input bit pe, input logic [31:0] pd);
    mode = 2'(m); rdAddrA = 4'(a); rdAddrB = 4'(b);
    wrEn = we; wrAddr = 4'(wa); wrData = wd; pcIncEn = pe; pcIncData = pd;
    #1;
    check(tag, "A", rdDataA, mdlRead(m, a));
    check(tag, "B", rdDataB, mdlRead(m, b));
    @(posedge clk);
    if (we && wa == 15)      pcModel = wd & PC_MASK;
    else if (pe)             pcModel = pd & PC_MASK;
    if (we && wa != 15)      view[owner(m, wa)][wa] = wd;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: PC cleared by reset
    step("R7 reset", 0, 15, 15, 0, 0, 0, 0, 0);

    // R2/R3: fill shared words, then the private copies of each mode
    for (int r = 0; r < 15; r++) step("R2 init", 0, 15, 15, 1, r, 32'h1000_0000 + r, 0, 0);
    for (int r = 10; r < 15; r++) step("R3 init fast", 1, 15, 15, 1, r, 32'h2000_0000 + r, 0, 0);
    for (int r = 13; r < 15; r++) step("R3 init irq", 2, 15, 15, 1, r, 32'h3000_0000 + r, 0, 0);
    for (int r = 13; r < 15; r++) step("R3 init svc", 3, 15, 15, 1, r, 32'h4000_0000 + r, 0, 0);

    // R3/R10/R11: every register in every mode on both ports
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 16; r++) step("R3 R10 R11 map", m, r, 15 - r, 0, 0, 0, 0, 0);
    step("R10 same reg", 2, 13, 13, 0, 0, 0, 0, 0);

    // R5: PC keeps only bits 25:2
    step("R5 pc write", 0, 15, 15, 1, 15, 32'hFFFF_FFFF, 0, 0);
    step("R5 pc read", 3, 15, 15, 0, 0, 0, 0, 0);

    // R9: PC path and normal write together
    step("R9 both", 0, 3, 15, 1, 3, 32'hCAFE_0003, 1, 32'h0000_1237);
    step("R9 check", 0, 3, 15, 0, 0, 0, 0, 0);

    // R8: normal write wins when both target r15
    step("R8 clash", 1, 15, 15, 1, 15, 32'h0ABC_DEF0, 1, 32'h0000_0040);
    step("R8 check", 1, 15, 15, 0, 0, 0, 0, 0);
    step("R8 inc", 0, 15, 15, 0, 0, 0, 1, 32'hFC00_0103);
    step("R8 inc check", 0, 15, 15, 0, 0, 0, 0, 0);

    // R6: read of the word being written returns old data
    step("R6 rdw", 0, 5, 5, 1, 5, 32'h5555_AAAA, 0, 0);
    step("R6 after", 0, 5, 5, 0, 0, 0, 0, 0);
    step("R6 banked rdw", 1, 12, 12, 1, 12, 32'h1212_1212, 0, 0);

    // R4: the mode of the write cycle picks the bank
    step("R4 irq write", 2, 13, 14, 1, 13, 32'hD00D_0013, 0, 0);
    step("R4 usr view", 0, 13, 14, 0, 0, 0, 0, 0);
    step("R4 svc view", 3, 13, 14, 0, 0, 0, 0, 0);
    step("R4 irq view", 2, 13, 14, 1, 12, 32'hBEEF_0012, 0, 0);
    step("R4 fast view", 1, 12, 13, 0, 0, 0, 0, 0);
    step("R4 usr r12", 0, 12, 12, 0, 0, 0, 0, 0);

    // Mixed traffic
    for (int i = 0; i < 400; i++)
      step("R1 R2 R3 R6 R8 R9 mixed", int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           32'($urandom), bit'($urandom_range(0, 1)), 32'($urandom));

    // R7: reset again clears the PC
    rst = 1'b1;
    @(posedge clk); pcModel = '0;
    @(negedge clk); rst = 1'b0;
    step("R7 re-reset", 2, 15, 15, 0, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule